// File: doc/BRIEF.md
# Hidden Address Latch Update Unit

This block keeps a copy of the 16-bit internal address register of an 8-bit CPU. Software cannot read or write this register directly. The core changes it as a side effect of many instructions. The instruction decoder asserts a commit strobe and a one-hot instruction-class code. It also presents every operand that an update rule may need: a 16-bit address or register pair, the accumulator, BC before and after the B decrement, the instruction address, the index-plus-displacement sum, an 8-bit port number and a compare-match indication. On a commit, the block applies the update formula for that class in a single clock cycle.

A clone-mode input selects the variant in which accumulator stores write zero into the high byte instead of the accumulator. The unit drives bits 11 and 13 of the register onto two outputs, so that a bit test through HL can copy them into flag bits 3 and 5. All arithmetic wraps modulo 2^16.

Top module: `shadow_addr_unit`

## Requirements
- R1: A synchronous active-low reset clears `addr_q` to 0x0000. The new value is visible after the first clock edge with `rst_n` low.
- R2: A commit with class bit 0 (load plus one) sets the register to `opnd_addr + 1`.
- R3: A commit with class bit 1 (accumulator store) sets bits 7:0 to the low byte of `opnd_addr + 1`. It sets bits 15:8 to `acc`, or to 0x00 when `clone_mode` is 1.
- R4: A commit with class bit 2 (control transfer) sets the register to `opnd_addr`.
- R5: A commit with class bit 3 (indexed access) sets the register to `idx_sum`.
- R6: Class bit 4 adds 1 to the current register value, and class bit 5 subtracts 1 from it. Both wrap at 16 bits.
- R7: Class bits 6 and 7 are repeating compares. A step is final when `bc_pre` equals 1 or `cmp_match` is 1. A final step behaves as R6 (bit 6 increments, bit 7 decrements). Any other step loads `instr_pc + 1`.
- R8: A commit with class bit 8 (immediate port input) sets the register to `{acc, port_num} + 1`.
- R9: Class bits 9 and 10 load `bc_pre + 1` and `bc_pre - 1`. Class bits 11 and 12 load `bc_post + 1` and `bc_post - 1`.
- R10: A commit with class bit 13 (repeating block move) leaves the register unchanged when `bc_pre` equals 1. Otherwise it loads `instr_pc + 1`.
- R11: The register keeps its value when `commit` is 0. It also keeps its value when `commit` is 1 and the class code does not have exactly one bit set.
- R12: `flag_b3` always equals register bit 11, and `flag_b5` always equals register bit 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| commit | input | 1 | Apply the update for the presented class this cycle |
| cls_onehot | input | 14 | One-hot instruction class, bit index as in R2 to R10 |
| clone_mode | input | 1 | Zero high byte on accumulator stores |
| opnd_addr | input | 16 | Absolute address, register pair, jump target or first operand |
| acc | input | 8 | Accumulator value before the instruction |
| bc_pre | input | 16 | BC before B is decremented |
| bc_post | input | 16 | BC after B is decremented |
| instr_pc | input | 16 | Address of the instruction |
| idx_sum | input | 16 | Index register plus displacement |
| port_num | input | 8 | Immediate port number |
| cmp_match | input | 1 | Compare step found A equal to memory |
| addr_q | output | 16 | Current hidden register value |
| flag_b3 | output | 1 | Register bit 11 |
| flag_b5 | output | 1 | Register bit 13 |

## Verification
The hardest rules to reach are the ones that depend on the register's own earlier value: the compare increments and decrements, the final steps of repeating compares, and the block move that holds its value at BC equal to 1. Their result is only meaningful when the starting value is a known, non-trivial one. The stimulus therefore walks through every class in a fixed order, in both variants, with operand patterns that sit on byte and word boundaries (0x00FF, 0x07FF, 0xFFFF and similar). Each rule is thus fed a register value left by a different earlier rule, and the wrap and carry cases are reached. The bench then changes the operand inputs while the strobe is low, or while the class code has zero, two or all bits set. After each such stimulus it confirms at the ports that the register and the flag outputs have not moved.

// File: rtl/shadow_addr_pkg.sv
// Package: class bit positions shared by the unit and its bench-facing docs.
// Assumes a decoder that drives exactly one class bit per committed instruction.
package shadow_addr_pkg;
    localparam int NCLS        = 14;
    localparam int C_ADDR_INC  = 0;
    localparam int C_ACC_STORE = 1;
    localparam int C_XFER      = 2;
    localparam int C_INDEXED   = 3;
    localparam int C_CMP_INC   = 4;
    localparam int C_CMP_DEC   = 5;
    localparam int C_CMPR_INC  = 6;
    localparam int C_CMPR_DEC  = 7;
    localparam int C_PORT_IN   = 8;
    localparam int C_BIN_INC   = 9;
    localparam int C_BIN_DEC   = 10;
    localparam int C_BOUT_INC  = 11;
    localparam int C_BOUT_DEC  = 12;
    localparam int C_BMOVE_REP = 13;
endpackage

// File: rtl/shadow_addr_calc.sv
// Module: computes one candidate next value per instruction class.
// Assumes AW == 2*DW so an accumulator byte fills exactly the high half.
module shadow_addr_calc
    import shadow_addr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0]           cur_q,
    input  logic                    clone_mode,
    input  logic [AW-1:0]           opnd_addr,
    input  logic [DW-1:0]           acc,
    input  logic [AW-1:0]           bc_pre,
    input  logic [AW-1:0]           bc_post,
    input  logic [AW-1:0]           instr_pc,
    input  logic [AW-1:0]           idx_sum,
    input  logic [DW-1:0]           port_num,
    input  logic                    cmp_match,
    output logic [NCLS-1:0][AW-1:0] cand
);
    localparam int            HW  = AW - DW;
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] addr_p1;
    logic [AW-1:0] pc_p1;
    logic [HW-1:0] store_hi;
    logic          bc_is_one;
    logic          cmp_final;

    // Shared operands: incremented address and PC, store high byte, step finality.
    always_comb begin
        addr_p1   = opnd_addr + ONE;
        pc_p1     = instr_pc + ONE;
        store_hi  = clone_mode ? '0 : HW'(acc);
        bc_is_one = (bc_pre == ONE);
        cmp_final = bc_is_one || cmp_match;
    end

    // One candidate per class; the class index selects the formula.
    for (genvar i = 0; i < NCLS; i++) begin : g_cls
        if (i == C_ADDR_INC) begin : g_ai
            assign cand[i] = addr_p1;
        end else if (i == C_ACC_STORE) begin : g_st
            assign cand[i] = {store_hi, addr_p1[DW-1:0]};
        end else if (i == C_XFER) begin : g_xf
            assign cand[i] = opnd_addr;
        end else if (i == C_INDEXED) begin : g_ix
            assign cand[i] = idx_sum;
        end else if (i == C_CMP_INC) begin : g_ci
            assign cand[i] = cur_q + ONE;
        end else if (i == C_CMP_DEC) begin : g_cd
            assign cand[i] = cur_q - ONE;
        end else if (i == C_CMPR_INC) begin : g_cri
            assign cand[i] = cmp_final ? (cur_q + ONE) : pc_p1;
        end else if (i == C_CMPR_DEC) begin : g_crd
            assign cand[i] = cmp_final ? (cur_q - ONE) : pc_p1;
        end else if (i == C_PORT_IN) begin : g_pi
            assign cand[i] = AW'({acc, port_num}) + ONE;
        end else if (i == C_BIN_INC) begin : g_bii
            assign cand[i] = bc_pre + ONE;
        end else if (i == C_BIN_DEC) begin : g_bid
            assign cand[i] = bc_pre - ONE;
        end else if (i == C_BOUT_INC) begin : g_boi
            assign cand[i] = bc_post + ONE;
        end else if (i == C_BOUT_DEC) begin : g_bod
            assign cand[i] = bc_post - ONE;
        end else begin : g_bm
            assign cand[i] = bc_is_one ? cur_q : pc_p1;
        end
    end
endmodule

// File: rtl/shadow_addr_sel.sv
// Module: picks the candidate named by a one-hot class and qualifies the load.
// Assumes candidates are packed by class index; non-one-hot codes never load.
module shadow_addr_sel
    import shadow_addr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                    commit,
    input  logic [NCLS-1:0]         cls_onehot,
    input  logic [NCLS-1:0][AW-1:0] cand,
    output logic                    load,
    output logic [AW-1:0]           nxt
);
    // AND-OR mux over the classes; valid only for exactly one set bit.
    always_comb begin
        nxt = '0;
        for (int i = 0; i < NCLS; i++) begin
            if (cls_onehot[i]) nxt = nxt | cand[i];
        end
        load = commit && ($countones(cls_onehot) == 1);
    end
endmodule

// File: rtl/shadow_addr_reg.sv
// Module: the hidden register itself with synchronous active-low reset.
// Assumes load and nxt are settled before the rising edge.
module shadow_addr_reg #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] nxt,
    output logic [AW-1:0] q
);
    // State update: clear on reset, else take the selected candidate.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= nxt;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> q == '0); // R1
    AST_NO_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R11
endmodule

// File: rtl/shadow_addr_unit.sv
// Module: top of the hidden address register update unit.
// Assumes the decoder presents all operands in the cycle commit is high.
module shadow_addr_unit
    import shadow_addr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [NCLS-1:0] cls_onehot,
    input  logic            clone_mode,
    input  logic [AW-1:0]   opnd_addr,
    input  logic [DW-1:0]   acc,
    input  logic [AW-1:0]   bc_pre,
    input  logic [AW-1:0]   bc_post,
    input  logic [AW-1:0]   instr_pc,
    input  logic [AW-1:0]   idx_sum,
    input  logic [DW-1:0]   port_num,
    input  logic            cmp_match,
    output logic [AW-1:0]   addr_q,
    output logic            flag_b3,
    output logic            flag_b5
);
    logic [NCLS-1:0][AW-1:0] cand;
    logic                    load;
    logic [AW-1:0]           nxt;

    shadow_addr_calc #(.AW(AW), .DW(DW)) u_calc (
        .cur_q(addr_q), .clone_mode(clone_mode), .opnd_addr(opnd_addr),
        .acc(acc), .bc_pre(bc_pre), .bc_post(bc_post), .instr_pc(instr_pc),
        .idx_sum(idx_sum), .port_num(port_num), .cmp_match(cmp_match),
        .cand(cand)
    );

    shadow_addr_sel #(.AW(AW)) u_sel (
        .commit(commit), .cls_onehot(cls_onehot), .cand(cand),
        .load(load), .nxt(nxt)
    );

    shadow_addr_reg #(.AW(AW)) u_reg (
        .clk(clk), .rst_n(rst_n), .load(load), .nxt(nxt), .q(addr_q)
    );

    // Flag taps for a bit test through HL.
    assign flag_b3 = addr_q[11];
    assign flag_b5 = addr_q[13];

    AST_BAD_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !$onehot(cls_onehot)) |=> $stable(addr_q)); // R11
    AST_XFER_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cls_onehot == NCLS'(1 << C_XFER)) |=> addr_q == $past(opnd_addr)); // R4
    AST_CMP_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cls_onehot == NCLS'(1 << C_CMP_INC)) |=> addr_q == AW'($past(addr_q) + 1)); // R6
    AST_CLONE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && clone_mode && cls_onehot == NCLS'(1 << C_ACC_STORE)) |=> addr_q[AW-1:DW] == '0); // R3
    AST_BMOVE_LAST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cls_onehot == NCLS'(1 << C_BMOVE_REP) && bc_pre == AW'(1)) |=> $stable(addr_q)); // R10
endmodule

// File: tb/shadow_addr_unit_bench.sv
`timescale 1ns/1ps
module shadow_addr_unit_bench;
    localparam int NC = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          commit = 1'b0;
    logic [NC-1:0] cls_onehot = '0;
    logic          clone_mode = 1'b0;
    logic [15:0]   opnd_addr = '0, bc_pre = '0, bc_post = '0, instr_pc = '0, idx_sum = '0;
    logic [7:0]    acc = '0, port_num = '0;
    logic          cmp_match = 1'b0;
    logic [15:0]   addr_q;
    logic          flag_b3, flag_b5;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] mdl = '0;

    always #2 clk = ~clk;

    shadow_addr_unit u_shadow_addr_unit (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cls_onehot(cls_onehot),
        .clone_mode(clone_mode), .opnd_addr(opnd_addr), .acc(acc),
        .bc_pre(bc_pre), .bc_post(bc_post), .instr_pc(instr_pc),
        .idx_sum(idx_sum), .port_num(port_num), .cmp_match(cmp_match),
        .addr_q(addr_q), .flag_b3(flag_b3), .flag_b5(flag_b5)
    );

    function automatic logic [15:0] pat(int k);
        case (k % 16)
            0: pat = 16'h0000;  1: pat = 16'h0001;  2: pat = 16'h00FF;  3: pat = 16'h0100;
            4: pat = 16'h07FF;  5: pat = 16'h0800;  6: pat = 16'h1FFF;  7: pat = 16'h2000;
            8: pat = 16'h7FFF;  9: pat = 16'h8000; 10: pat = 16'hA5A5; 11: pat = 16'h5A5A;
            12: pat = 16'hF7FF; 13: pat = 16'hFFFE; 14: pat = 16'hFFFF; default: pat = 16'h1234;
        endcase
    endfunction

    function automatic string rtag(int c);
        case (c)
            0: rtag = "R2";  1: rtag = "R3";  2: rtag = "R4";  3: rtag = "R5";
            4, 5: rtag = "R6";  6, 7: rtag = "R7";  8: rtag = "R8";
            9, 10, 11, 12: rtag = "R9";  default: rtag = "R10";
        endcase
    endfunction

    // Expected value derived from the requirement text for class c.
    function automatic logic [15:0] expect_val(int c, logic [15:0] cur);
        logic fin;
        fin = (bc_pre == 16'd1) || cmp_match;
        case (c)
            0: expect_val = opnd_addr + 16'd1;
            1: expect_val = {clone_mode ? 8'h00 : acc, 8'(opnd_addr + 16'd1)};
            2: expect_val = opnd_addr;
            3: expect_val = idx_sum;
            4: expect_val = cur + 16'd1;
            5: expect_val = cur - 16'd1;
            6: expect_val = fin ? cur + 16'd1 : instr_pc + 16'd1;
            7: expect_val = fin ? cur - 16'd1 : instr_pc + 16'd1;
            8: expect_val = (16'(acc) << 8) + 16'(port_num) + 16'd1;
            9: expect_val = bc_pre + 16'd1;
            10: expect_val = bc_pre - 16'd1;
            11: expect_val = bc_post + 16'd1;
            12: expect_val = bc_post - 16'd1;
            default: expect_val = (bc_pre == 16'd1) ? cur : instr_pc + 16'd1;
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] exp_v);
        n_chk++;
        if (addr_q !== exp_v) begin
            n_bad++;
            $display("FAIL %s addr_q actual=%h expected=%h", tag, addr_q, exp_v);
        end
        n_chk++;
        if (flag_b3 !== exp_v[11] || flag_b5 !== exp_v[13]) begin
            n_bad++;
            $display("FAIL R12 flags actual=%b%b expected=%b%b", flag_b5, flag_b3, exp_v[13], exp_v[11]);
        end
    endtask

    // Drive one commit at the falling edge, check after the next rising edge.
    task automatic strobe(logic [NC-1:0] code, logic [15:0] exp_v, string tag);
        cls_onehot = code;
        commit = 1'b1;
        @(posedge clk);
        @(negedge clk);
        commit = 1'b0;
        cls_onehot = '0;
        mdl = exp_v;
        check(tag, mdl);
    endtask

    task automatic set_ops(int k);
        opnd_addr = pat(k);
        acc       = pat(k + 3)[7:0] ^ 8'(k * 37);
        port_num  = pat(k + 2)[15:8] ^ 8'(k);
        bc_pre    = (k % 4 == 0) ? 16'd1 : pat(k + 5);
        bc_post   = pat(k + 7);
        instr_pc  = pat(k + 9);
        idx_sum   = pat(k + 11);
        cmp_match = (k % 4 == 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        mdl = 16'h0000;
        check("R1", mdl);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep every class over all operand patterns in both variants.
        for (int v = 0; v < 2; v++) begin
            clone_mode = v[0];
            for (int c = 0; c < NC; c++) begin
                for (int k = 0; k < 16; k++) begin
                    set_ops(k + c);
                    strobe(NC'(1) << c, expect_val(c, mdl), rtag(c));
                end
            end
        end

        // R11: inputs move while commit is low; register must not follow.
        for (int k = 0; k < 8; k++) begin
            set_ops(k * 3);
            cls_onehot = NC'(1) << (k % NC);
            @(posedge clk);
            @(negedge clk);
            check("R11", mdl);
        end
        // R11: commit with zero, two-hot and all-ones codes is ignored.
        set_ops(5);
        strobe('0, mdl, "R11");
        strobe(NC'(3), mdl, "R11");
        strobe(NC'(14'h2004), mdl, "R11");
        strobe('1, mdl, "R11");

        // R1: reset mid-run clears the register.
        set_ops(14);
        strobe(NC'(1) << 2, 16'hFFFF, "R4");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mdl = 16'h0000;
        check("R1", mdl);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule